// File: doc/BRIEF.md
# Linear-Count Display Timing Generator

This block produces horizontal sync, vertical sync, data-enable and the outgoing colour for a raster panel. Within a line it counts pixels. Over the frame it keeps one running count of pixel clocks from the start of the frame instead of a line number. Software therefore programs the vertical sync width and the vertical display window as absolute pixel-clock counts, for example the active start as (vtotal - vsync_start) * htotal + skew. The horizontal window is programmed relative to the leading edge of the hsync pulse, and the period registers hold htotal and vtotal * htotal.

All timing values, the skew and the polarity bits are captured into shadow registers at a frame boundary. The global enable is captured at the same boundary. Software can therefore reprogram a mode, or clear the enable, at any time during a frame. The running frame finishes on the old values, and the next frame uses the new ones. When the block is idle, the boundary occurs on every clock, so enabling takes effect on the next edge. The colour path drives a border colour outside the display window. When pixel data is missing inside the window and recovery is on, it drives a fill colour instead.

Top module: `lctg_top`

## Requirements
- R1: The line counter runs from 0 to `hs_period`-1 and then wraps to 0. `hsync` is active while the line count is below `hs_width`.
- R2: The frame counter advances by one on every pixel clock from 0 to `vs_period`-1. Both counters restart at 0 on the clock after the last count of the frame. The line count is therefore the frame count modulo `hs_period`.
- R3: `vsync` is active while the frame count f satisfies `hs_skew` <= f < `hs_skew` + `vs_len`.
- R4: `de` is 1 exactly when `disp_hstart` <= line count <= `disp_hend` and `disp_vstart` <= frame count <= `disp_vend`, with both bounds inclusive.
- R5: `hs_low` = 1 makes `hsync` active-low and `vs_low` = 1 makes `vsync` active-low. An inactive sync sits at the level of its polarity bit.
- R6: When `de` is 0, `rgb` equals `border_color`.
- R7: When `de` is 1 and `pix_valid` is 1, `rgb` equals `pix_data`. When `de` is 1 and `pix_valid` is 0, `rgb` equals `fill_color` if `recover_en` is 1, and `pix_data` otherwise.
- R8: `frame_irq` is high for exactly one clock, in the cycle holding the last count of a running frame.
- R9: From idle, `active` and the counters start (frame count 0) on the clock after `enable` is seen high. Clearing `enable` during a frame has no effect until that frame ends. After the frame ends, `active`, `de`, `frame_irq` are 0 and both syncs are inactive.
- R10: The period, width, window, skew and polarity inputs are sampled only at a frame boundary. A change made mid-frame leaves the outputs of the current frame unchanged.
- R11: During reset, `active`, `de` and `frame_irq` are 0, and `hsync` and `vsync` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global run request, sampled at frame boundary |
| hs_period | input | HW | Pixels per line |
| hs_width | input | HW | Hsync pulse width in pixels |
| hs_skew | input | HW | Delay of vsync from frame start in pixel clocks |
| disp_hstart | input | HW | First displayed pixel of a line |
| disp_hend | input | HW | Last displayed pixel of a line |
| vs_period | input | FW | Pixel clocks per frame |
| vs_len | input | FW | Vsync width in pixel clocks |
| disp_vstart | input | FW | First displayed frame count |
| disp_vend | input | FW | Last displayed frame count |
| hs_low | input | 1 | Hsync active-low when 1 |
| vs_low | input | 1 | Vsync active-low when 1 |
| border_color | input | CW | Colour outside the display window |
| fill_color | input | CW | Colour substituted on underflow |
| recover_en | input | 1 | Enables fill colour on underflow |
| pix_data | input | CW | Incoming pixel |
| pix_valid | input | 1 | Incoming pixel present |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgb | output | CW | Outgoing colour |
| frame_irq | output | 1 | One-clock pulse at frame end |
| active | output | 1 | Generator running |

## Verification
The bench compares every output on every clock across whole frames against arithmetic on a modelled frame position. It targets these corner cases:

- A frame length that htotal does not divide. A design that did not restart the line counter at frame end would drift its hsync phase there.
- A nonzero skew. A design that ignored it would start vsync too early.
- Inclusive window edges. An off-by-one comparison would shorten or lengthen `de` by a pixel or a line.
- A reprogrammed mode and a cleared enable written mid-frame. A design without shadowing would glitch the current frame or stop it short.
- Underflow with recovery on and off. A design that got this wrong would leak stale or fill data.

// File: rtl/lctg_pkg.sv
package lctg_pkg;
   typedef enum logic [1:0] {
      SRC_BORDER = 2'd0,
      SRC_PIXEL  = 2'd1,
      SRC_FILL   = 2'd2
   } lctg_src_e;

   function automatic lctg_src_e pick_src(input logic de, input logic valid,
                                          input logic recover);
      if (!de)                  return SRC_BORDER;
      else if (!valid && recover) return SRC_FILL;
      else                      return SRC_PIXEL;
   endfunction
endpackage

// File: rtl/lctg_hcount.sv
module lctg_hcount #(
   parameter int unsigned HW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [HW-1:0] period,
   input  logic [HW-1:0] width,
   input  logic [HW-1:0] win_lo,
   input  logic [HW-1:0] win_hi,
   output logic [HW-1:0] hcnt,
   output logic          hs_act,
   output logic          h_in
);
   logic line_end;

   assign line_end = (hcnt == period - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hcnt <= '0;
      else if (restart)  hcnt <= '0;
      else if (line_end) hcnt <= '0;
      else               hcnt <= hcnt + 1'b1;
   end

   assign hs_act = (hcnt < width);
   assign h_in   = (hcnt >= win_lo) && (hcnt <= win_hi);
endmodule

// File: rtl/lctg_fcount.sv
module lctg_fcount #(
   parameter int unsigned FW = 24,
   parameter int unsigned HW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [FW-1:0] period,
   input  logic [FW-1:0] sync_len,
   input  logic [HW-1:0] skew,
   input  logic [FW-1:0] win_lo,
   input  logic [FW-1:0] win_hi,
   output logic [FW-1:0] fcnt,
   output logic          last,
   output logic          vs_act,
   output logic          v_in
);
   localparam int unsigned EW = FW + 1;

   logic [EW-1:0] skew_x;
   logic [EW-1:0] sync_end;
   logic [EW-1:0] fcnt_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fcnt <= '0;
      else if (restart) fcnt <= '0;
      else              fcnt <= fcnt + 1'b1;
   end

   assign last     = (fcnt == period - 1'b1);
   assign skew_x   = EW'(skew);
   assign fcnt_x   = {1'b0, fcnt};
   assign sync_end = skew_x + {1'b0, sync_len};
   assign vs_act   = (fcnt_x >= skew_x) && (fcnt_x < sync_end);
   assign v_in     = (fcnt >= win_lo) && (fcnt <= win_hi);
endmodule

// File: rtl/lctg_pixmux.sv
module lctg_pixmux
   import lctg_pkg::*;
#(
   parameter int unsigned CW             = 24,
   parameter bit          UNDERFLOW_FILL = 1'b1
) (
   input  logic          de,
   input  logic          pix_valid,
   input  logic          recover_en,
   input  logic [CW-1:0] pix_data,
   input  logic [CW-1:0] fill_color,
   input  logic [CW-1:0] border_color,
   output logic [CW-1:0] rgb
);
   logic      rec_eff;
   lctg_src_e src;

   generate
      if (UNDERFLOW_FILL) begin : g_fill
         assign rec_eff = recover_en;
      end else begin : g_nofill
         logic unused_rec;
         assign unused_rec = recover_en;
         assign rec_eff    = 1'b0;
      end
   endgenerate

   assign src = pick_src(de, pix_valid, rec_eff);

   always_comb begin
      unique case (src)
         SRC_BORDER: rgb = border_color;
         SRC_FILL:   rgb = fill_color;
         default:    rgb = pix_data;
      endcase
   end
endmodule

// File: rtl/lctg_top.sv
module lctg_top #(
   parameter int unsigned HW             = 12,
   parameter int unsigned FW             = 24,
   parameter int unsigned CW             = 24,
   parameter bit          UNDERFLOW_FILL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [HW-1:0] hs_period,
   input  logic [HW-1:0] hs_width,
   input  logic [HW-1:0] hs_skew,
   input  logic [HW-1:0] disp_hstart,
   input  logic [HW-1:0] disp_hend,
   input  logic [FW-1:0] vs_period,
   input  logic [FW-1:0] vs_len,
   input  logic [FW-1:0] disp_vstart,
   input  logic [FW-1:0] disp_vend,
   input  logic          hs_low,
   input  logic          vs_low,
   input  logic [CW-1:0] border_color,
   input  logic [CW-1:0] fill_color,
   input  logic          recover_en,
   input  logic [CW-1:0] pix_data,
   input  logic          pix_valid,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [CW-1:0] rgb,
   output logic          frame_irq,
   output logic          active
);
   initial begin
      assert (HW >= 2) else $error("lctg_top: HW must be at least 2");
      assert (FW >= HW) else $error("lctg_top: FW must not be narrower than HW");
      assert (CW >= 1) else $error("lctg_top: CW must be positive");
   end

   logic          run;
   logic          load;
   logic          wrap;
   logic [HW-1:0] sh_hper, sh_hwid, sh_skew, sh_hlo, sh_hhi;
   logic [FW-1:0] sh_vper, sh_vlen, sh_vlo, sh_vhi;
   logic          sh_hlow, sh_vlow;
   logic [HW-1:0] hcnt;
   logic [FW-1:0] fcnt;
   logic          f_last, hs_act, vs_act, h_in, v_in;

   assign wrap = run & f_last;
   assign load = ~run | wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         sh_hper <= '0;
         sh_hwid <= '0;
         sh_skew <= '0;
         sh_hlo  <= '0;
         sh_hhi  <= '0;
         sh_vper <= '0;
         sh_vlen <= '0;
         sh_vlo  <= '0;
         sh_vhi  <= '0;
         sh_hlow <= 1'b0;
         sh_vlow <= 1'b0;
      end else if (load) begin
         run     <= enable;
         sh_hper <= hs_period;
         sh_hwid <= hs_width;
         sh_skew <= hs_skew;
         sh_hlo  <= disp_hstart;
         sh_hhi  <= disp_hend;
         sh_vper <= vs_period;
         sh_vlen <= vs_len;
         sh_vlo  <= disp_vstart;
         sh_vhi  <= disp_vend;
         sh_hlow <= hs_low;
         sh_vlow <= vs_low;
      end
   end

   lctg_hcount #(.HW(HW)) u_hcount (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .period  (sh_hper),
      .width   (sh_hwid),
      .win_lo  (sh_hlo),
      .win_hi  (sh_hhi),
      .hcnt    (hcnt),
      .hs_act  (hs_act),
      .h_in    (h_in)
   );

   lctg_fcount #(.FW(FW), .HW(HW)) u_fcount (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (load),
      .period   (sh_vper),
      .sync_len (sh_vlen),
      .skew     (sh_skew),
      .win_lo   (sh_vlo),
      .win_hi   (sh_vhi),
      .fcnt     (fcnt),
      .last     (f_last),
      .vs_act   (vs_act),
      .v_in     (v_in)
   );

   assign hsync     = (run & hs_act) ^ sh_hlow;
   assign vsync     = (run & vs_act) ^ sh_vlow;
   assign de        = run & h_in & v_in;
   assign frame_irq = wrap;
   assign active    = run;

   lctg_pixmux #(.CW(CW), .UNDERFLOW_FILL(UNDERFLOW_FILL)) u_pixmux (
      .de           (de),
      .pix_valid    (pix_valid),
      .recover_en   (recover_en),
      .pix_data     (pix_data),
      .fill_color   (fill_color),
      .border_color (border_color),
      .rgb          (rgb)
   );
endmodule

// File: rtl/lctg_chk.sv
module lctg_chk #(
   parameter int unsigned HW = 12,
   parameter int unsigned FW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic [HW-1:0] hcnt,
   input logic [FW-1:0] fcnt,
   input logic [HW-1:0] sh_hper,
   input logic          frame_irq,
   input logic          de
);
   // R2
   frame_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !frame_irq |=> fcnt == $past(fcnt) + 1'b1);

   // R1
   line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !frame_irq && hcnt == sh_hper - 1'b1 |=> hcnt == '0);

   // R9
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !frame_irq |=> run);

   // R10
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !frame_irq |=> $stable(sh_hper));

   // R4
   de_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> run);

   // R8
   irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_irq |-> run);
endmodule

bind lctg_top lctg_chk #(.HW(HW), .FW(FW)) u_lctg_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .hcnt      (hcnt),
   .fcnt      (fcnt),
   .sh_hper   (sh_hper),
   .frame_irq (frame_irq),
   .de        (de)
);

// File: tb/test_lctg_top.sv
`timescale 1ns/1ps
module test_lctg_top;
   localparam int HW = 12;
   localparam int FW = 24;
   localparam int CW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [HW-1:0] hs_period = '0, hs_width = '0, hs_skew = '0, disp_hstart = '0, disp_hend = '0;
   logic [FW-1:0] vs_period = '0, vs_len = '0, disp_vstart = '0, disp_vend = '0;
   logic          hs_low = 1'b0, vs_low = 1'b0;
   logic [CW-1:0] border_color = 24'h102030, fill_color = 24'h0000FF;
   logic          recover_en = 1'b1;
   logic [CW-1:0] pix_data = '0;
   logic          pix_valid = 1'b1;
   logic          hsync, vsync, de, frame_irq, active;
   logic [CW-1:0] rgb;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model of the requirements
   int m_run = 0, m_f = 0, m_h = 0, k = 0;
   int e_hp, e_hw, e_sk, e_hs, e_he, e_vp, e_vl, e_vs, e_ve, e_hl, e_vlo;

   always #2 clk = ~clk;

   lctg_top #(.HW(HW), .FW(FW), .CW(CW)) i_lctg_top (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .hs_period(hs_period), .hs_width(hs_width), .hs_skew(hs_skew),
      .disp_hstart(disp_hstart), .disp_hend(disp_hend),
      .vs_period(vs_period), .vs_len(vs_len),
      .disp_vstart(disp_vstart), .disp_vend(disp_vend),
      .hs_low(hs_low), .vs_low(vs_low),
      .border_color(border_color), .fill_color(fill_color), .recover_en(recover_en),
      .pix_data(pix_data), .pix_valid(pix_valid),
      .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb),
      .frame_irq(frame_irq), .active(active)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at step %0d: actual %0h expected %0h", req, k, act, exp);
      end
   endtask

   task automatic set_cfg(input int hp, hw, sk, hs, he, vp, vl, vs, ve, hl, vlo);
      hs_period = HW'(hp); hs_width = HW'(hw); hs_skew = HW'(sk);
      disp_hstart = HW'(hs); disp_hend = HW'(he);
      vs_period = FW'(vp); vs_len = FW'(vl);
      disp_vstart = FW'(vs); disp_vend = FW'(ve);
      hs_low = hl[0]; vs_low = vlo[0];
   endtask

   task automatic model_edge();
      if (m_run == 0 || m_f == e_vp - 1) begin
         m_run = enable ? 1 : 0;
         m_f = 0; m_h = 0;
         e_hp = hs_period; e_hw = hs_width; e_sk = hs_skew;
         e_hs = disp_hstart; e_he = disp_hend;
         e_vp = vs_period; e_vl = vs_len; e_vs = disp_vstart; e_ve = disp_vend;
         e_hl = hs_low; e_vlo = vs_low;
      end else begin
         m_f++;
         m_h = m_f % e_hp;
      end
   endtask

   // one clock: model update at the edge, drive pixel, check at mid-low phase
   task automatic step();
      int hact, vact, de_e, irq_e;
      logic [CW-1:0] rgb_e;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      pix_data  = CW'((k * 37) ^ 24'hA5C3E1);
      pix_valid = (k % 7) != 3;
      #0.5;
      hact  = (m_run != 0) && (m_h < e_hw);
      vact  = (m_run != 0) && (m_f >= e_sk) && (m_f < e_sk + e_vl);
      de_e  = (m_run != 0) && (m_h >= e_hs) && (m_h <= e_he) && (m_f >= e_vs) && (m_f <= e_ve);
      irq_e = (m_run != 0) && (m_f == e_vp - 1);
      if (!de_e) rgb_e = border_color;
      else if (!pix_valid && recover_en) rgb_e = fill_color;
      else rgb_e = pix_data;
      chk("R1/R5 hsync", int'(hsync), hact ^ e_hl);
      chk("R3/R5 vsync", int'(vsync), vact ^ e_vlo);
      chk("R4 de", int'(de), de_e);
      chk(de_e ? "R7 rgb" : "R6 rgb", int'(rgb), int'(rgb_e));
      chk("R8 frame_irq", int'(frame_irq), irq_e);
      chk("R9 active", int'(active), m_run);
      k++;
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R11: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 active", int'(active), 0);
      chk("R11 de", int'(de), 0);
      chk("R11 frame_irq", int'(frame_irq), 0);
      chk("R11 hsync", int'(hsync), 0);
      chk("R11 vsync", int'(vsync), 0);

      // mode A: htotal 8, hdisp 4, hss 5, hse 6; vtotal 6, vdisp 3, vss 4, vse 5; skew 0
      set_cfg(8, 1, 0, 3, 6, 48, 8, 16, 39, 0, 0);
      rst_n = 1'b1;
      e_vp = 1;
      repeat (4) step();          // idle with enable low: R9 idle outputs
      enable = 1'b1;              // R9: start on next edge
      repeat (100) step();

      // R10: mode B written mid-frame (skew 3, active-low syncs)
      while (m_f != 20) step();
      set_cfg(8, 2, 3, 3, 6, 48, 8, 19, 42, 1, 1);
      repeat (110) step();

      // R7: recovery off
      recover_en = 1'b0;
      repeat (60) step();
      recover_en = 1'b1;

      // R2: frame length not a multiple of the line, written mid-frame
      set_cfg(7, 3, 5, 2, 4, 45, 5, 10, 30, 0, 1);
      repeat (150) step();

      // R9: clear enable mid-frame; runs to the frame end then idles
      while (m_f != 12) step();
      enable = 1'b0;
      repeat (80) step();

      // restart after idle with a skewed, wide-sync mode, then stop again
      set_cfg(9, 4, 2, 0, 8, 54, 18, 0, 53, 1, 0);
      enable = 1'b1;
      repeat (120) step();
      enable = 1'b0;
      repeat (70) step();

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule